// File: doc/BRIEF.md
# Inverting Data Bus Codec for an Active-Low 64-bit Path

This block limits how many wires of a 64-bit active-low data bus are pulled low in any single data phase. The path is cut into four 16-bit lanes. Each lane carries one inversion flag, and that flag is itself an active-low wire. On the transmit side the block takes one 64-bit phase per cycle. It counts the ones in each lane separately, inverts every lane that holds more than half ones, and drives the resulting wire levels together with the four flag wires. Eight phases make up one 64-byte line. The block tracks its position inside the line and marks the eighth phase.

The receive side undoes the coding. It takes wire levels and flag wires from the bus, turns them back into logical values, and flips each lane whose flag is asserted. Both directions use one registered valid/ready stage. A phase accepted on a rising edge appears on the outputs after that edge. Back-pressure is plain: an input is taken only while the output register is empty or is being drained in the same cycle (`*_in_ready = !*_out_valid || *_out_ready`). A held output does not change until it is taken. When no phase is pending, the transmit wires rest at the bus idle level, which is all high with no flag asserted.

Top module: `dbi_codec`

## Requirements
- R1: Flag k (tx_flag_n[k], rx_flag_n[k]) governs data bits 16k+15 down to 16k, for k = 0..3.
- R2: On transmit, a lane is inverted and its flag asserted when its logical data holds more than 8 ones. A lane with exactly 8 ones or fewer is sent unchanged with its flag deasserted. As a result, at most 9 wires per lane are low, counting the flag wire.
- R3: The bus is active-low. A transmitted logical 1 is a low wire (0 on tx_bus_n), and an asserted flag is a low flag wire (0 on tx_flag_n).
- R4: The inversion choice is made afresh for every phase and every lane. It does not depend on earlier phases.
- R5: Transmit handshake: tx_in_ready equals !tx_out_valid || tx_out_ready. A phase accepted on an edge appears on tx_bus_n/tx_flag_n/tx_last after that edge. The outputs and tx_out_valid hold steady while tx_out_valid is high and tx_out_ready is low.
- R6: tx_last is high on the eighth accepted phase of each line. rx_out_last is high on the eighth accepted received phase. Both phase counts wrap to zero after the eighth phase.
- R7: Receive: rx_out_data equals the inverse of rx_bus_n, with each lane flipped when its rx_flag_n wire is low. The result is registered with the same handshake rule as R5.
- R8: Encoding and then decoding returns the original 64-bit data for any pattern, including all-zero and all-one.
- R9: After reset, tx_out_valid and rx_out_valid are low, tx_bus_n and tx_flag_n are all ones, rx_out_data is zero, and both phase counts are zero.
- R10: Whenever tx_out_valid is low, tx_bus_n and tx_flag_n are all ones and tx_last is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_valid | input | 1 | Transmit phase offered |
| tx_in_ready | output | 1 | Transmit phase can be taken |
| tx_in_data | input | 64 | Logical data of one phase |
| tx_out_valid | output | 1 | Encoded phase on the wires |
| tx_out_ready | input | 1 | Bus side takes the encoded phase |
| tx_bus_n | output | 64 | Data wire levels (low = logical 1) |
| tx_flag_n | output | 4 | Lane inversion flag wires (low = inverted) |
| tx_last | output | 1 | Eighth phase of a line |
| rx_in_valid | input | 1 | Received phase offered |
| rx_in_ready | output | 1 | Received phase can be taken |
| rx_bus_n | input | 64 | Received data wire levels |
| rx_flag_n | input | 4 | Received flag wire levels |
| rx_out_valid | output | 1 | Decoded phase available |
| rx_out_ready | input | 1 | Consumer takes the decoded phase |
| rx_out_data | output | 64 | Decoded logical data |
| rx_out_last | output | 1 | Eighth received phase of a line |

## Verification
The all-zero and all-one phases show whether the flag is used in the right direction: all-zero data must leave every wire high, and all-one data must also leave the data wires high but with every flag low. Lanes holding exactly 8 and exactly 9 ones sit on either side of the threshold, so they separate a "more than half" rule from an "at least half" rule. Phases that mix both kinds of lane, placed in a different order from one phase to the next, show that the choice is made per lane and per phase. Random phases fed back through the receiver test the full round trip. A stalled output with a second phase waiting tests hold and back-pressure, and also checks that the line position keeps counting.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  parameter int unsigned DBI_LANES  = 4;
  parameter int unsigned DBI_LANE_W = 16;
  parameter int unsigned DBI_BEATS  = 8;

  // A lane flips when its count of ones is strictly above this value.
  function automatic int unsigned flip_limit(input int unsigned lane_w);
    return lane_w / 2;
  endfunction
endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc #(
  parameter int unsigned LANE_W = 16
) (
  input  logic [LANE_W-1:0] d,
  output logic [LANE_W-1:0] q,
  output logic              flip
);
  localparam int unsigned CW = $clog2(LANE_W + 1);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < LANE_W; i++) begin
      ones = ones + CW'(d[i]);
    end
  end

  assign flip = (ones > CW'(dbi_pkg::flip_limit(LANE_W)));
  assign q    = flip ? ~d : d;
endmodule

// File: rtl/dbi_beat_ctr.sv
module dbi_beat_ctr #(
  parameter int unsigned BEATS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic at_end
);
  localparam int unsigned CW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  logic [CW-1:0] cnt;

  assign at_end = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dbi_reg_stage.sv
module dbi_reg_stage #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_pay,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_pay
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pay   <= IDLE;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_pay   <= in_pay;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_pay   <= IDLE;
    end
  end
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec #(
  parameter int unsigned LANES  = dbi_pkg::DBI_LANES,
  parameter int unsigned LANE_W = dbi_pkg::DBI_LANE_W,
  parameter int unsigned BEATS  = dbi_pkg::DBI_BEATS,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_in_valid,
  output logic             tx_in_ready,
  input  logic [DW-1:0]    tx_in_data,
  output logic             tx_out_valid,
  input  logic             tx_out_ready,
  output logic [DW-1:0]    tx_bus_n,
  output logic [LANES-1:0] tx_flag_n,
  output logic             tx_last,
  input  logic             rx_in_valid,
  output logic             rx_in_ready,
  input  logic [DW-1:0]    rx_bus_n,
  input  logic [LANES-1:0] rx_flag_n,
  output logic             rx_out_valid,
  input  logic             rx_out_ready,
  output logic [DW-1:0]    rx_out_data,
  output logic             rx_out_last
);
  localparam int unsigned PW = DW + LANES + 1;
  localparam logic [PW-1:0] TX_IDLE = {{(DW + LANES){1'b1}}, 1'b0};
  localparam logic [DW:0]   RX_IDLE = '0;

  // Transmit: per-lane encode, then convert logical levels to wire levels.
  logic [DW-1:0]    enc_data;
  logic [LANES-1:0] enc_flip;
  logic             tx_end;

  for (genvar k = 0; k < LANES; k++) begin : g_tx_lane
    dbi_lane_enc #(.LANE_W(LANE_W)) u_enc (
      .d    (tx_in_data[k*LANE_W +: LANE_W]),
      .q    (enc_data[k*LANE_W +: LANE_W]),
      .flip (enc_flip[k])
    );
  end

  dbi_beat_ctr #(.BEATS(BEATS)) u_tx_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (tx_in_valid && tx_in_ready),
    .at_end (tx_end)
  );

  logic [PW-1:0] tx_pay_in, tx_pay_out;
  assign tx_pay_in = {~enc_data, ~enc_flip, tx_end};

  dbi_reg_stage #(.W(PW), .IDLE(TX_IDLE)) u_tx_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_pay    (tx_pay_in),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_pay   (tx_pay_out)
  );

  assign {tx_bus_n, tx_flag_n, tx_last} = tx_pay_out;

  // Receive: wire levels back to logical, each lane XORed with its flag.
  logic [DW-1:0] rx_mask;
  logic          rx_end;

  for (genvar k = 0; k < LANES; k++) begin : g_rx_lane
    assign rx_mask[k*LANE_W +: LANE_W] = {LANE_W{~rx_flag_n[k]}};
  end

  dbi_beat_ctr #(.BEATS(BEATS)) u_rx_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (rx_in_valid && rx_in_ready),
    .at_end (rx_end)
  );

  logic [DW:0] rx_pay_in, rx_pay_out;
  assign rx_pay_in = {(~rx_bus_n) ^ rx_mask, rx_end};

  dbi_reg_stage #(.W(DW + 1), .IDLE(RX_IDLE)) u_rx_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_pay    (rx_pay_in),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_pay   (rx_pay_out)
  );

  assign {rx_out_data, rx_out_last} = rx_pay_out;
endmodule

// File: rtl/dbi_codec_chk.sv
module dbi_codec_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 16,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_in_valid,
  input logic             tx_in_ready,
  input logic             tx_out_valid,
  input logic             tx_out_ready,
  input logic [DW-1:0]    tx_bus_n,
  input logic [LANES-1:0] tx_flag_n,
  input logic             tx_last,
  input logic             rx_in_valid,
  input logic             rx_in_ready,
  input logic             rx_out_valid,
  input logic             rx_out_ready,
  input logic [DW-1:0]    rx_out_data,
  input logic             rx_out_last
);
  localparam int unsigned MAX_LOW = LANE_W / 2 + 1;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    AST_LANE_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tx_out_valid |-> ($countones(~tx_bus_n[k*LANE_W +: LANE_W]) + (tx_flag_n[k] ? 0 : 1)) <= MAX_LOW); // R2
  end

  AST_TX_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_out_valid |-> (&tx_bus_n) && (&tx_flag_n) && !tx_last); // R10

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_bus_n) && $stable(tx_flag_n) && $stable(tx_last)); // R5

  AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_valid && tx_in_ready |=> tx_out_valid); // R5

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && !rx_out_ready |=> rx_out_valid && $stable(rx_out_data) && $stable(rx_out_last)); // R7

  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid && rx_in_ready |=> rx_out_valid); // R7

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_last |-> rx_out_valid); // R6
endmodule

bind dbi_codec dbi_codec_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/dbi_codec_bench.sv
module dbi_codec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_in_valid = 1'b0;
  logic        tx_in_ready;
  logic [63:0] tx_in_data = '0;
  logic        tx_out_valid;
  logic        tx_out_ready = 1'b1;
  logic [63:0] tx_bus_n;
  logic [3:0]  tx_flag_n;
  logic        tx_last;
  logic        rx_in_valid = 1'b0;
  logic        rx_in_ready;
  logic [63:0] rx_bus_n = '1;
  logic [3:0]  rx_flag_n = '1;
  logic        rx_out_valid;
  logic        rx_out_ready = 1'b1;
  logic [63:0] rx_out_data;
  logic        rx_out_last;

  int total = 0;
  int bad = 0;
  int tx_beat = 0;
  int rx_beat = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dbi_codec u_dbi_codec (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog: act=%0d expected<=20000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  function automatic logic [3:0] exp_flags(input logic [63:0] d);
    logic [3:0] f;
    for (int k = 0; k < 4; k++) f[k] = ($countones(d[k*16 +: 16]) > 8);
    return f;
  endfunction

  function automatic logic [63:0] exp_wires(input logic [63:0] d);
    logic [63:0] m;
    logic [3:0]  f;
    f = exp_flags(d);
    for (int k = 0; k < 4; k++) m[k*16 +: 16] = {16{f[k]}};
    return ~(d ^ m);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // Sends one phase, checks encode, loops it to the receiver, checks decode.
  task automatic run_phase(input logic [63:0] d, input string tag);
    logic [63:0] w;
    logic [3:0]  f;
    int          worst;
    @(negedge clk);
    tx_in_valid = 1'b1;
    tx_in_data  = d;
    @(negedge clk);
    tx_in_valid = 1'b0;
    w = exp_wires(d);
    f = ~exp_flags(d);
    chk(tx_out_valid == 1'b1, {"R5 valid ", tag}, 64'(tx_out_valid), 64'd1);
    chk(tx_bus_n == w, {"R2 R3 wires ", tag}, tx_bus_n, w);
    chk(tx_flag_n == f, {"R1 R3 flags ", tag}, 64'(tx_flag_n), 64'(f));
    chk(tx_last == (tx_beat == 7), {"R6 tx_last ", tag}, 64'(tx_last), 64'(tx_beat == 7));
    worst = 0;
    for (int k = 0; k < 4; k++) begin
      int lo;
      lo = $countones(~tx_bus_n[k*16 +: 16]) + (tx_flag_n[k] ? 0 : 1);
      if (lo > worst) worst = lo;
    end
    chk(worst <= 9, {"R2 low bound ", tag}, 64'(worst), 64'd9);
    tx_beat = (tx_beat + 1) % 8;
    rx_in_valid = 1'b1;
    rx_bus_n    = tx_bus_n;
    rx_flag_n   = tx_flag_n;
    @(negedge clk);
    rx_in_valid = 1'b0;
    chk(!tx_out_valid && (&tx_bus_n) && (&tx_flag_n), {"R10 idle ", tag}, tx_bus_n, '1);
    chk(rx_out_valid && rx_out_data == d, {"R7 R8 roundtrip ", tag}, rx_out_data, d);
    chk(rx_out_last == (rx_beat == 7), {"R6 rx_last ", tag}, 64'(rx_out_last), 64'(rx_beat == 7));
    rx_beat = (rx_beat + 1) % 8;
  endtask

  initial begin
    logic [63:0] a, b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!tx_out_valid && !rx_out_valid && tx_in_ready, "R9 reset valids", 64'(tx_out_valid), 64'd0);
    chk((&tx_bus_n) && (&tx_flag_n) && rx_out_data == '0, "R9 reset idle", tx_bus_n, '1);
    rst_n = 1'b1;

    // Directed line: threshold and mixed-lane cases (R2, R4).
    run_phase(64'h0, "zeros");
    run_phase('1, "ones");
    run_phase(64'h00FF_0F0F_3333_5555, "eight ones");
    run_phase(64'h01FF_01FF_01FF_01FF, "nine ones");
    run_phase(64'h0000_FFFF_01FF_00FF, "R4 mix a");
    run_phase(64'h00FF_01FF_FFFF_0000, "R4 mix b");
    run_phase(64'h0001_FFFE_8000_7FFF, "edge bits");
    run_phase({$urandom, $urandom}, "rand");

    // Back-pressure: hold A while B waits (R5), both counted (R6).
    @(negedge clk);
    tx_out_ready = 1'b0;
    a = 64'hFFFF_0000_F0F0_FF01;
    b = 64'h1234_ABCD_FFFF_0003;
    tx_in_valid = 1'b1;
    tx_in_data  = a;
    @(negedge clk);
    tx_in_data = b;
    chk(tx_in_ready == 1'b0, "R5 ready low when stalled", 64'(tx_in_ready), 64'd0);
    repeat (2) @(negedge clk);
    chk(tx_out_valid && tx_bus_n == exp_wires(a), "R5 hold under stall", tx_bus_n, exp_wires(a));
    chk(tx_last == (tx_beat == 7), "R6 stalled beat last", 64'(tx_last), 64'(tx_beat == 7));
    tx_beat = (tx_beat + 1) % 8;
    tx_out_ready = 1'b1;
    @(negedge clk);
    tx_in_valid = 1'b0;
    chk(tx_out_valid && tx_bus_n == exp_wires(b) && tx_flag_n == ~exp_flags(b),
        "R5 next phase after release", tx_bus_n, exp_wires(b));
    chk(tx_last == (tx_beat == 7), "R6 after release last", 64'(tx_last), 64'(tx_beat == 7));
    tx_beat = (tx_beat + 1) % 8;
    @(negedge clk);
    chk(!tx_out_valid && (&tx_bus_n), "R10 idle after drain", tx_bus_n, '1);

    // Random traffic over several lines.
    for (int i = 0; i < 30; i++) begin
      run_phase({$urandom, $urandom}, "rand");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule